// File: doc/BRIEF.md
# Rotating-Top Floating Register Stack

This block holds the eight extended-precision (80-bit) operand registers of a floating-point unit. Software and the arithmetic pipeline never name a physical register: they name a slot relative to the current top of stack, ST0 being the top and STi the entry i places below it. A 3-bit top pointer picks which physical register is ST0. A push or a pop only moves that pointer and updates a 2-bit tag per register, so no data moves between registers when the stack is renamed.

Each register carries a tag of 00 (holds a value) or 11 (empty). The tags let the block detect faults before any state changes. A push onto a register that is still in use raises a sticky overflow flag. A pop or read of an empty top raises a sticky underflow flag. In either case the stack is left exactly as it was. Two bulk commands exist. Empty-all marks every register free. A write through the 64-bit packed-integer alias, which addresses registers by physical number, marks every register valid.

Commands arrive on a valid/ready port, one per cycle. Data leaves on a valid/ready result port. A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high, and all state updates at that edge. Commands that return data (pop and read) place a result on the output port at the same edge. `cmd_ready` is low exactly while a result is held and `rd_ready` is low, so a result is never overwritten. A result stays on `rd_data` with `rd_valid` high until the cycle `rd_ready` is high. The top pointer, tags and fault flags are plain status outputs.

Top module: `fp_reg_stack`

## Requirements
- R1: Reset and the init command (opcode 8) set the top pointer to 0, set every tag to 11 and clear both fault flags. After reset `rd_valid` is 0.
- R2: Push (opcode 1) takes `wr_data` and puts it in the new ST0. The old STi becomes ST(i+1). The top pointer decrements modulo 8 (from 0 to 7) and the new top's tag becomes 00.
- R3: A push whose target register has a tag other than 11 sets the sticky overflow flag `flag_ovf`. It leaves the top pointer, the tags and the stored data unchanged. Only reset or init clears the flag.
- R4: Pop (opcode 2) returns ST0 on `rd_data` with `rd_valid`, sets that register's tag to 11 and increments the top pointer modulo 8.
- R5: Read (opcode 3) returns ST0 on `rd_data` with `rd_valid` and changes no state.
- R6: Pop, read or write-and-pop with an empty ST0, or exchange where either ST0 or STi is empty, sets the sticky underflow flag `flag_unf` and changes no register, tag or pointer. A pop or read that underflows still returns a result, and that result is all zeros.
- R7: Exchange (opcode 4, index i in `cmd_idx`) swaps the contents of ST0 and STi. With i = 0 nothing changes.
- R8: Write (opcode 5, index i) stores `wr_data` into STi, with i = 0 meaning the top, and sets its tag to 00. The pointer does not move.
- R9: Write-and-pop (opcode 6, index i) stores `wr_data` into STi and then pops, so the value lands in what becomes ST(i−1). With i = 0 the written value is discarded by the pop.
- R10: Empty-all (opcode 7) sets every tag to 11 and leaves the top pointer, the flags and the data unchanged.
- R11: Alias write (opcode 9) addresses physical register `cmd_idx`. It replaces bits 63:0 of that register with `wr_data[63:0]`, keeps bits 79:64, sets all tags to 00 and leaves the pointer unchanged.
- R12: `cmd_ready` = !`rd_valid` || `rd_ready`. While `rd_ready` is low, a pending result keeps `rd_valid` high and `rd_data` stable, and no command is accepted.
- R13: `tag_word[2k+1:2k]` is the tag of physical register k, and `top_ptr` is the physical index of ST0. Opcode 0 and opcodes 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_idx | input | 3 | Relative slot i, or physical register for alias write |
| wr_data | input | 80 | Value for push, write and alias write |
| rd_valid | output | 1 | Result available |
| rd_ready | input | 1 | Consumer takes the result |
| rd_data | output | 80 | Result of pop or read |
| top_ptr | output | 3 | Physical index of ST0 |
| tag_word | output | 16 | Tag of every physical register, 2 bits each |
| flag_ovf | output | 1 | Sticky stack overflow |
| flag_unf | output | 1 | Sticky stack underflow |

## Verification
The bench targets three kinds of error. The first is pointer wrap: the first push after init must land in physical register 7, and a design that does not wrap modulo 8 would point ST0 at the wrong register. The second is stack faults: the ninth push and pops, exchanges and write-pops on an empty top are driven on purpose. A design that wrote before it checked the tag would corrupt a live value or move the pointer where it must hold. The third is the exchange sweep and the write-pop with index 0, which catch swapped or stale read addresses and wrong priority when one register is both written and freed. A long pseudo-random command stream, checked against an arithmetic model, exercises the alias write's partial update, the result stall under back-pressure and the renaming in general.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_PUSH  = 4'd1,
    OP_POP   = 4'd2,
    OP_READ  = 4'd3,
    OP_XCHG  = 4'd4,
    OP_WRITE = 4'd5,
    OP_WRPOP = 4'd6,
    OP_EMPTY = 4'd7,
    OP_INIT  = 4'd8,
    OP_ALIAS = 4'd9
  } stk_op_e;

  typedef enum logic [1:0] {
    SRC_IN    = 2'd0,
    SRC_SWAP  = 2'd1,
    SRC_MERGE = 2'd2
  } wsrc_e;

  localparam logic [1:0] TAG_VALID = 2'b00;
  localparam logic [1:0] TAG_EMPTY = 2'b11;
endpackage

// File: rtl/fpstk_regs.sv
module fpstk_regs #(
  parameter int DEPTH = 8,
  parameter int W     = 80,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] ra_addr,
  input  logic [PTR_W-1:0] rb_addr,
  output logic [W-1:0]     ra_data,
  output logic [W-1:0]     rb_data,
  input  logic             we_a,
  input  logic [PTR_W-1:0] wa_addr,
  input  logic [W-1:0]     wd_a,
  input  logic             we_b,
  input  logic [PTR_W-1:0] wb_addr,
  input  logic [W-1:0]     wd_b
);
  logic [DEPTH-1:0][W-1:0] mem;

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (we_a && wa_addr == PTR_W'(k)) begin
        q <= wd_a;
      end else if (we_b && wb_addr == PTR_W'(k)) begin
        q <= wd_b;
      end
    end
    assign mem[k] = q;
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/fpstk_ctl.sv
module fpstk_ctl
  import fpstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  stk_op_e            op,
  input  logic [PTR_W-1:0]   idx,
  output logic [PTR_W-1:0]   top_o,
  output logic [2*DEPTH-1:0] tags_o,
  output logic               ovf_o,
  output logic               unf_o,
  output logic [PTR_W-1:0]   ra_addr,
  output logic [PTR_W-1:0]   rb_addr,
  output logic               we_a,
  output logic [PTR_W-1:0]   wa_addr,
  output wsrc_e              src_a,
  output logic               we_b,
  output logic [PTR_W-1:0]   wb_addr,
  output logic               rd_go,
  output logic               rd_zero
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] top_q;
  logic [1:0]       tag_q [DEPTH];
  logic             ovf_q, unf_q;

  logic [PTR_W-1:0] p0, pi, ps;
  logic             e0, ei, slot_busy;

  assign p0        = top_q;
  assign pi        = top_q + idx;
  assign ps        = top_q - ONE;
  assign e0        = (tag_q[p0] == TAG_EMPTY);
  assign ei        = (tag_q[pi] == TAG_EMPTY);
  assign slot_busy = (tag_q[ps] != TAG_EMPTY);

  // Data-side write strobes; every fault suppresses them
  always_comb begin
    ra_addr = (op == OP_ALIAS) ? idx : p0;
    rb_addr = pi;
    we_a    = 1'b0;
    wa_addr = pi;
    src_a   = SRC_IN;
    we_b    = 1'b0;
    wb_addr = pi;
    if (fire) begin
      case (op)
        OP_PUSH: begin
          we_a    = !slot_busy;
          wa_addr = ps;
        end
        OP_XCHG: begin
          we_a    = !(e0 || ei);
          wa_addr = p0;
          src_a   = SRC_SWAP;
          we_b    = !(e0 || ei);
        end
        OP_WRITE: we_a = 1'b1;
        OP_WRPOP: we_a = !e0;
        OP_ALIAS: begin
          we_a    = 1'b1;
          wa_addr = idx;
          src_a   = SRC_MERGE;
        end
        default: ;
      endcase
    end
  end

  assign rd_go   = fire && (op == OP_POP || op == OP_READ);
  assign rd_zero = e0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      for (int k = 0; k < DEPTH; k++) tag_q[k] <= TAG_EMPTY;
    end else if (fire) begin
      case (op)
        OP_PUSH: begin
          if (slot_busy) ovf_q <= 1'b1;
          else begin
            tag_q[ps] <= TAG_VALID;
            top_q     <= ps;
          end
        end
        OP_POP: begin
          if (e0) unf_q <= 1'b1;
          else begin
            tag_q[p0] <= TAG_EMPTY;
            top_q     <= p0 + ONE;
          end
        end
        OP_READ: if (e0) unf_q <= 1'b1;
        OP_XCHG: if (e0 || ei) unf_q <= 1'b1;
        OP_WRITE: tag_q[pi] <= TAG_VALID;
        OP_WRPOP: begin
          if (e0) unf_q <= 1'b1;
          else begin
            tag_q[pi] <= TAG_VALID;
            tag_q[p0] <= TAG_EMPTY;   // later assignment wins when idx is 0
            top_q     <= p0 + ONE;
          end
        end
        OP_EMPTY: for (int k = 0; k < DEPTH; k++) tag_q[k] <= TAG_EMPTY;
        OP_INIT: begin
          top_q <= '0;
          ovf_q <= 1'b0;
          unf_q <= 1'b0;
          for (int k = 0; k < DEPTH; k++) tag_q[k] <= TAG_EMPTY;
        end
        OP_ALIAS: for (int k = 0; k < DEPTH; k++) tag_q[k] <= TAG_VALID;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_tag
    assign tags_o[2*k +: 2] = tag_q[k];
  end

  assign top_o = top_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  assert_push_rename_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_PUSH && !slot_busy) |=> (top_q == $past(top_q) - ONE));

  assert_no_overflow_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_PUSH && slot_busy) |=> ($stable(top_q) && $stable(tags_o) && ovf_q));

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(fire && op == OP_INIT)) |=> ovf_q);

  assert_underflow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (op == OP_POP || op == OP_READ) && e0) |=> ($stable(top_q) && $stable(tags_o) && unf_q));

  assert_init_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_INIT) |=> (top_q == '0 && tags_o == '1 && !ovf_q && !unf_q));

  assert_alias_tags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_ALIAS) |=> (tags_o == '0 && $stable(top_q)));

  assert_empty_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_EMPTY) |=> (tags_o == '1 && $stable(top_q)));
endmodule

// File: rtl/fpstk_rdout.sv
module fpstk_rdout #(
  parameter int W = 80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         rd_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         ready_o
);
  assign ready_o = !rd_valid || rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (load) begin
      rd_valid <= 1'b1;
      rd_data  <= load_data;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_no_overwrite_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |-> !load);
endmodule

// File: rtl/fp_reg_stack.sv
module fp_reg_stack
  import fpstk_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int WIDTH   = 80,
  parameter int ALIAS_W = 64,
  parameter int OP_W    = 4,
  parameter int PTR_W   = $clog2(DEPTH),
  parameter int TAGS_W  = 2 * DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [PTR_W-1:0]  cmd_idx,
  input  logic [WIDTH-1:0]  wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WIDTH-1:0]  rd_data,
  output logic [PTR_W-1:0]  top_ptr,
  output logic [TAGS_W-1:0] tag_word,
  output logic              flag_ovf,
  output logic              flag_unf
);
  stk_op_e          op;
  logic             fire;
  logic [PTR_W-1:0] ra_addr, rb_addr, wa_addr, wb_addr;
  logic             we_a, we_b, rd_go, rd_zero;
  wsrc_e            src_a;
  logic [WIDTH-1:0] ra_data, rb_data, wd_a;

  assign op   = stk_op_e'(cmd_op);
  assign fire = cmd_valid && cmd_ready;

  fpstk_ctl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .fire(fire), .op(op), .idx(cmd_idx),
    .top_o(top_ptr), .tags_o(tag_word), .ovf_o(flag_ovf), .unf_o(flag_unf),
    .ra_addr(ra_addr), .rb_addr(rb_addr), .we_a(we_a), .wa_addr(wa_addr),
    .src_a(src_a), .we_b(we_b), .wb_addr(wb_addr), .rd_go(rd_go), .rd_zero(rd_zero)
  );

  always_comb begin
    case (src_a)
      SRC_SWAP:  wd_a = rb_data;
      SRC_MERGE: wd_a = {ra_data[WIDTH-1:ALIAS_W], wr_data[ALIAS_W-1:0]};
      default:   wd_a = wr_data;
    endcase
  end

  fpstk_regs #(.DEPTH(DEPTH), .W(WIDTH), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(ra_addr), .rb_addr(rb_addr), .ra_data(ra_data), .rb_data(rb_data),
    .we_a(we_a), .wa_addr(wa_addr), .wd_a(wd_a),
    .we_b(we_b), .wb_addr(wb_addr), .wd_b(ra_data)
  );

  fpstk_rdout #(.W(WIDTH)) u_rdout (
    .clk(clk), .rst_n(rst_n), .load(rd_go),
    .load_data(rd_zero ? '0 : ra_data),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .ready_o(cmd_ready)
  );
endmodule

// File: tb/test_fp_reg_stack.sv
module test_fp_reg_stack;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [2:0]  cmd_idx = '0;
  logic [79:0] wr_data = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [79:0] rd_data;
  logic [2:0]  top_ptr;
  logic [15:0] tag_word;
  logic        flag_ovf, flag_unf;

  always #(CLK_P/2) clk = ~clk;

  fp_reg_stack i_fp_reg_stack (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .top_ptr(top_ptr), .tag_word(tag_word), .flag_ovf(flag_ovf), .flag_unf(flag_unf)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model
  logic [79:0] m [8];
  logic [1:0]  mt [8];
  logic [2:0]  mtop;
  logic        mo, mu, exp_rv;
  logic [79:0] exp_rd;

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_tags();
    logic [15:0] t;
    for (int k = 0; k < 8; k++) t[2*k +: 2] = mt[k];
    return t;
  endfunction

  function automatic logic [79:0] val(input int k);
    return {16'h3F00 + 16'(k), 64'hA5A5_0000_0000_0000 ^ (64'(k) * 64'h0001_0203_0405_0607)};
  endfunction

  task automatic model_init();
    mtop = 0; mo = 0; mu = 0;
    for (int k = 0; k < 8; k++) begin mt[k] = 2'b11; m[k] = '0; end
  endtask

  task automatic model(input logic [3:0] op, input logic [2:0] idx, input logic [79:0] d);
    logic [2:0] p0, pi, ps;
    logic [79:0] t;
    p0 = mtop; pi = mtop + idx; ps = mtop - 3'd1;
    exp_rv = 0; exp_rd = '0;
    case (op)
      4'd1: if (mt[ps] != 2'b11) mo = 1; else begin m[ps] = d; mt[ps] = 0; mtop = ps; end
      4'd2: begin
        exp_rv = 1;
        if (mt[p0] == 2'b11) mu = 1;
        else begin exp_rd = m[p0]; mt[p0] = 2'b11; mtop = p0 + 3'd1; end
      end
      4'd3: begin
        exp_rv = 1;
        if (mt[p0] == 2'b11) mu = 1; else exp_rd = m[p0];
      end
      4'd4: if (mt[p0] == 2'b11 || mt[pi] == 2'b11) mu = 1;
            else begin t = m[p0]; m[p0] = m[pi]; m[pi] = t; end
      4'd5: begin m[pi] = d; mt[pi] = 0; end
      4'd6: if (mt[p0] == 2'b11) mu = 1;
            else begin m[pi] = d; mt[pi] = 0; mt[p0] = 2'b11; mtop = p0 + 3'd1; end
      4'd7: for (int k = 0; k < 8; k++) mt[k] = 2'b11;
      4'd8: begin mtop = 0; mo = 0; mu = 0; for (int k = 0; k < 8; k++) mt[k] = 2'b11; end
      4'd9: begin m[idx][63:0] = d[63:0]; for (int k = 0; k < 8; k++) mt[k] = 0; end
      default: ;
    endcase
  endtask

  task automatic compare(input string req);
    chk(top_ptr == mtop, req, 80'(top_ptr), 80'(mtop));
    chk(tag_word == exp_tags(), req, 80'(tag_word), 80'(exp_tags()));
    chk(flag_ovf == mo && flag_unf == mu, req, 80'({flag_ovf, flag_unf}), 80'({mo, mu}));
    chk(rd_valid == exp_rv, req, 80'(rd_valid), 80'(exp_rv));
    if (exp_rv) chk(rd_data == exp_rd, req, rd_data, exp_rd);
  endtask

  task automatic do_cmd(input logic [3:0] op, input logic [2:0] idx, input logic [79:0] d, input string req);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_idx = idx; wr_data = d;
    chk(cmd_ready == 1'b1, "R12", 80'(cmd_ready), 80'(1));
    @(negedge clk);
    cmd_valid = 0;
    model(op, idx, d);
    compare(req);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    logic [79:0] held;
    model_init();
    repeat (3) @(negedge clk);
    exp_rv = 0;
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");

    // underflow on empty stack, then init clears it
    do_cmd(4'd3, 0, '0, "R6");
    do_cmd(4'd2, 0, '0, "R6");
    do_cmd(4'd8, 0, '0, "R1");

    // fill: first push wraps to register 7
    for (int k = 0; k < 8; k++) do_cmd(4'd1, 0, val(k), "R2");
    do_cmd(4'd3, 0, '0, "R5");
    do_cmd(4'd1, 0, val(99), "R3");
    do_cmd(4'd3, 0, '0, "R3");
    do_cmd(4'd0, 0, val(5), "R3");
    for (int i = 0; i < 8; i++) begin
      do_cmd(4'd4, 3'(i), '0, "R7");
      do_cmd(4'd3, 0, '0, "R7");
    end
    for (int i = 0; i < 8; i++) do_cmd(4'd5, 3'(i), val(20 + i), "R8");
    do_cmd(4'd6, 3'd3, val(40), "R9");
    do_cmd(4'd6, 3'd0, val(41), "R9");
    for (int k = 0; k < 7; k++) do_cmd(4'd2, 0, '0, "R4");
    do_cmd(4'd2, 0, '0, "R6");
    do_cmd(4'd6, 3'd1, val(42), "R6");
    do_cmd(4'd13, 3'd2, val(43), "R13");

    // empty-all
    do_cmd(4'd8, 0, '0, "R1");
    for (int k = 0; k < 3; k++) do_cmd(4'd1, 0, val(50 + k), "R2");
    do_cmd(4'd7, 0, '0, "R10");
    do_cmd(4'd3, 0, '0, "R10");
    for (int k = 0; k < 8; k++) do_cmd(4'd1, 0, val(60 + k), "R10");

    // exchange against an empty slot
    do_cmd(4'd8, 0, '0, "R1");
    do_cmd(4'd1, 0, val(70), "R2");
    do_cmd(4'd4, 3'd2, '0, "R6");
    do_cmd(4'd5, 3'd0, val(71), "R8");
    do_cmd(4'd3, 0, '0, "R8");

    // alias writes, then drain everything
    for (int k = 0; k < 8; k++) do_cmd(4'd9, 3'(k), {16'h0, 64'h1111_0000_0000_0000 + 64'(k)}, "R11");
    for (int k = 0; k < 8; k++) do_cmd(4'd2, 0, '0, "R11");

    // back-pressure
    do_cmd(4'd1, 0, val(80), "R2");
    @(negedge clk);
    rd_ready = 0; cmd_valid = 1; cmd_op = 4'd3; cmd_idx = 0;
    @(negedge clk);
    model(4'd3, 0, '0);
    held = exp_rd;
    cmd_op = 4'd1; wr_data = val(81);
    for (int c = 0; c < 3; c++) begin
      chk(cmd_ready == 1'b0, "R12", 80'(cmd_ready), 80'(0));
      chk(rd_valid == 1'b1 && rd_data == held, "R12", rd_data, held);
      chk(top_ptr == mtop, "R12", 80'(top_ptr), 80'(mtop));
      @(negedge clk);
    end
    cmd_valid = 0; rd_ready = 1;
    @(negedge clk);
    exp_rv = 0;
    compare("R12");

    // pseudo-random sweep against the model
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] o;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      o = (lf[7:4] % 4'd11 == 4'd8 && lf[9]) ? 4'd1 : 4'(lf[7:4] % 4'd11);
      if (o == 4'd10) o = 4'd15;
      do_cmd(o, lf[12:10], {lf, lf, lf[15:0]} ^ 80'(n), "R13");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule